// File: doc/BRIEF.md
# Opcode-Driven Half-Duplex SPI Host Engine

This block is a memory-mapped SPI host that runs one command each time software fires it. A command has three parts, always in this order: a single opcode byte taken from the control register, then a programmed number of transmit bytes fetched from a small byte-addressed FIFO, then a programmed number of receive bytes captured from the serial input. The receive bytes are written back into the same FIFO, directly behind the transmit bytes. Software reads them there once the busy flag has dropped.

Software programs the opcode, the two byte counts and a chip-select number through a 32-bit register bus with byte strobes. Single-byte accesses use a single strobe. Software then sets the execute bit. The engine pulls one of four active-low selects low and clocks the bytes out MSB first in SPI mode 0. During the receive phase it samples MISO on rising SCLK edges. Busy reads as 1 until the select has been released.

The register bus has no back-pressure. A write is taken in the cycle `bus_write` is high, and `bus_rdata` follows `bus_addr` combinationally. The serial side has no flow control either. The engine paces itself from `HALF_CYC`, and the device must keep up.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, busy reads 0, all four `spi_cs_n` are high and `spi_sclk` is low. The opcode, chip-select and count registers all read 0.
- R2: The word at 0x00 holds the opcode in bits [7:0]. Writing 1 to bit 16 starts a command. Bit 16 always reads 0, because the request clears itself when the command is taken. Bit 31 reads 1 from the cycle after the starting write until the command has ended.
- R3: The opcode goes out first, followed by transmit-count bytes read from FIFO offsets starting at the engine pointer. Every byte is sent MSB first in mode 0: SCLK idles low, MOSI is stable around each rising edge, and each SCLK level lasts at least `HALF_CYC` clocks.
- R4: Bits [1:0] of byte 0x1D (word 0x1C, bits [9:8]) select the chip select: value n drives `spi_cs_n[n]` low for the command. The other three selects stay high, and the selection does not change while that select is low.
- R5: After the transmit bytes, receive-count bytes are shifted in from MISO. Received byte j is stored at FIFO offset (pointer at start + transmit count + j). MOSI stays 0 for the whole receive phase, and no byte is stored during the opcode or transmit phases.
- R6: The transmit count is the byte at 0x48 and the receive count is the byte at 0x4B. A command produces exactly 8×(1+tx+rx) rising SCLK edges, so with both counts zero only the opcode is sent.
- R7: FIFO byte i is written and read at address 0x80+i, on byte lane i mod 4 of word 0x80+4·⌊i/4⌋.
- R8: While busy is 1, writes to the opcode, counts, chip-select byte and FIFO have no effect. A second execute request is also ignored.
- R9: Writing 1 to bit 20 of word 0x00 while idle returns the engine pointer to 0. The bit reads back 0. A command started without a clear continues from the offset where the previous command stopped.
- R10: SCLK stays low whenever no select is low. The select goes low at least `HALF_CYC` clocks before the first rising edge, and it returns high before busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_write | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address; bits [1:0] are ignored and the word is chosen by [7:2] |
| bus_wstrb | input | 4 | Byte-lane enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The bench builds the engine with a 72-byte FIFO and `HALF_CYC` = 2. With these values one byte takes only about 34 clocks, so a command that fills the FIFO completely (70 transmit bytes plus 2 received bytes landing in the last two entries) fits easily in the run. That puts the top of the FIFO window and the largest offsets of received data within reach. Commands with zero counts, with only receive bytes and with only transmit bytes use each of the four selects, and a run without a pointer clear shows the pointer carrying over between commands.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_state_t;
  typedef enum logic [1:0] {PH_OPC, PH_TX, PH_RX} eng_phase_t;

  // word indices (byte address >> 2) that the software sequence depends on
  localparam logic [5:0] W_CTRL = 6'h00;
  localparam logic [5:0] W_CSEL = 6'h07;
  localparam logic [5:0] W_CNT  = 6'h12;
endpackage

// File: rtl/spi_fifo_ram.sv
module spi_fifo_ram #(
  parameter int DEPTH = 72,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_base,
  input  logic [3:0]       bus_strb,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [7:0]       eng_wdata,
  output logic [7:0]       eng_rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] lane_idx [4];
  logic [3:0]       lane_ok;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane_idx[g] = bus_base + IDX_W'(g);
    assign lane_ok[g]  = lane_idx[g] < LIMIT;
    assign bus_rdata[8*g +: 8] = lane_ok[g] ? mem[lane_idx[g][AW-1:0]] : 8'h00;
  end

  assign eng_rdata = (eng_idx < LIMIT) ? mem[eng_idx[AW-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (bus_we && bus_strb[l] && lane_ok[l])
        mem[lane_idx[l][AW-1:0]] <= bus_wdata[8*l +: 8];
    end
    if (eng_we && (eng_idx < LIMIT))
      mem[eng_idx[AW-1:0]] <= eng_wdata;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done
);
  localparam int CNT_W = $clog2(HALF_CYC) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  logic             active, high;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       shreg;

  assign mosi = shreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      high    <= 1'b0;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      rx_byte <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shreg  <= tx_byte;
        active <= 1'b1;
        high   <= 1'b0;
        cnt    <= '0;
        bitn   <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (cnt == CNT_LAST) begin
          cnt <= '0;
          if (!high) begin
            sclk    <= 1'b1;
            high    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk <= 1'b0;
            high <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn  <= bitn + 1'b1;
              shreg <= {shreg[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_BYTES = 72,
  parameter int HALF_CYC   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [3:0]  bus_wstrb,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [3:0]  spi_cs_n
);
  localparam int PTR_W = 9;
  localparam int CNT_W = $clog2(HALF_CYC) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  eng_state_t       state;
  eng_phase_t       phase;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       opcode_q, tx_cnt_q, rx_cnt_q, tx_left, rx_left;
  logic [1:0]       cs_sel_q;
  logic [PTR_W-1:0] ptr;
  logic             exec_q, clr_q, busy;
  logic             sh_start, sh_done;
  logic [7:0]       sh_byte, sh_rx, ram_eng_rd;
  logic [31:0]      ram_bus_rd;

  // ---------------- register bus decode ----------------
  logic [5:0]       word_sel;
  logic             fifo_hit, wr_idle, ctrl_wr, exec_wr, clr_wr;
  logic [PTR_W-1:0] bus_base;
  logic [1:0]       unused_addr;

  assign unused_addr = bus_addr[1:0];
  assign word_sel    = bus_addr[7:2];
  assign fifo_hit    = bus_addr[7];
  assign bus_base    = {2'b00, bus_addr[6:2], 2'b00};
  assign busy        = (state != ST_IDLE) || exec_q;
  assign wr_idle     = bus_write && !busy;
  assign ctrl_wr     = wr_idle && !fifo_hit && (word_sel == W_CTRL);
  assign exec_wr     = ctrl_wr && bus_wstrb[2] && bus_wdata[16];
  assign clr_wr      = ctrl_wr && bus_wstrb[2] && bus_wdata[20];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
      cs_sel_q <= '0;
    end else if (wr_idle && !fifo_hit) begin
      case (word_sel)
        W_CTRL: if (bus_wstrb[0]) opcode_q <= bus_wdata[7:0];
        W_CSEL: if (bus_wstrb[1]) cs_sel_q <= bus_wdata[9:8];
        W_CNT: begin
          if (bus_wstrb[0]) tx_cnt_q <= bus_wdata[7:0];
          if (bus_wstrb[3]) rx_cnt_q <= bus_wdata[31:24];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (fifo_hit) begin
      bus_rdata = ram_bus_rd;
    end else begin
      case (word_sel)
        W_CTRL: begin
          bus_rdata[31]  = busy;
          bus_rdata[7:0] = opcode_q;
        end
        W_CSEL: bus_rdata[9:8] = cs_sel_q;
        W_CNT: begin
          bus_rdata[7:0]   = tx_cnt_q;
          bus_rdata[31:24] = rx_cnt_q;
        end
        default: ;
      endcase
    end
  end

  // ---------------- shared FIFO storage ----------------
  logic eng_we;
  assign eng_we = (state == ST_SHIFT) && sh_done && (phase == PH_RX);

  spi_fifo_ram #(.DEPTH(FIFO_BYTES), .IDX_W(PTR_W)) u_ram (
    .clk       (clk),
    .bus_we    (wr_idle && fifo_hit),
    .bus_base  (bus_base),
    .bus_strb  (bus_wstrb),
    .bus_wdata (bus_wdata),
    .bus_rdata (ram_bus_rd),
    .eng_we    (eng_we),
    .eng_idx   (ptr),
    .eng_wdata (sh_rx),
    .eng_rdata (ram_eng_rd)
  );

  // ---------------- serial shifter ----------------
  spi_byte_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (sh_byte),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .rx_byte (sh_rx),
    .done    (sh_done)
  );

  // ---------------- command sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_OPC;
      cnt      <= '0;
      tx_left  <= '0;
      rx_left  <= '0;
      ptr      <= '0;
      exec_q   <= 1'b0;
      clr_q    <= 1'b0;
      sh_start <= 1'b0;
      sh_byte  <= '0;
      spi_cs_n <= '1;
    end else begin
      exec_q   <= exec_wr;
      clr_q    <= clr_wr;
      sh_start <= 1'b0;
      case (state)
        ST_IDLE: if (exec_q) begin
          state    <= ST_LEAD;
          cnt      <= '0;
          tx_left  <= tx_cnt_q;
          rx_left  <= rx_cnt_q;
          spi_cs_n <= ~(4'b0001 << cs_sel_q);
        end
        ST_LEAD: if (cnt == CNT_LAST) begin
          sh_start <= 1'b1;
          sh_byte  <= opcode_q;
          phase    <= PH_OPC;
          state    <= ST_SHIFT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_SHIFT: if (sh_done) begin
          if (phase == PH_RX) ptr <= ptr + 1'b1;
          if (tx_left != 8'd0) begin
            sh_start <= 1'b1;
            sh_byte  <= ram_eng_rd;
            ptr      <= ptr + 1'b1;
            tx_left  <= tx_left - 1'b1;
            phase    <= PH_TX;
          end else if (rx_left != 8'd0) begin
            sh_start <= 1'b1;
            sh_byte  <= 8'h00;
            rx_left  <= rx_left - 1'b1;
            phase    <= PH_RX;
          end else begin
            state <= ST_TRAIL;
            cnt   <= '0;
          end
        end
        ST_TRAIL: if (cnt == CNT_LAST) begin
          spi_cs_n <= '1;
          state    <= ST_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
      if (clr_q) ptr <= '0;
    end
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       exec_q,
  input logic       clr_q
);
  assert_single_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  assert_cs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |=> ((&cs_n) || $stable(cs_n)));

  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk);

  assert_cs_within_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |-> busy);

  assert_exec_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |=> !exec_q);

  assert_clear_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (spi_cs_n),
  .sclk   (spi_sclk),
  .busy   (busy),
  .exec_q (exec_q),
  .clr_q  (clr_q)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
  localparam int DEPTH = 72;
  localparam int HALF  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;

  always #2 clk = ~clk;

  spi_cmd_engine #(.FIFO_BYTES(DEPTH), .HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  int checks = 0, errors = 0;
  logic [7:0] mdl [DEPTH];
  int mptr = 0;
  logic [7:0] exp_q [$];
  int cur_tx = 0, seed = 3, bitn = 0, sclk_rises = 0;
  logic [7:0] mshift = '0;
  logic [7:0] rb;
  logic cs_low;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reply_f(input int k, input int s);
    return 8'((k * 29 + s) ^ 8'h5A);
  endfunction

  // ---------- serial device model and scoreboard monitor ----------
  assign cs_low = ~&cs_n;
  assign rb     = reply_f(bitn / 8, seed);
  assign miso   = rb[3'(7 - (bitn % 8))];

  always @(posedge cs_low) bitn = 0;

  always @(posedge sclk) begin
    if (!cs_low) begin
      check(0, "R10 sclk rose with no select", 32'(cs_n), 32'hF);
    end else begin
      mshift = {mshift[6:0], mosi};
      bitn++;
      sclk_rises++;
      if (bitn % 8 == 0) begin
        if (bitn / 8 - 1 < 1 + cur_tx) begin
          if (exp_q.size() == 0) check(0, "R3 unexpected byte", 32'(mshift), 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(mshift == e, "R3 mosi byte", 32'(mshift), 32'(e));
          end
        end else begin
          check(mshift == 8'h00, "R5 mosi low while receiving", 32'(mshift), 0);
        end
      end
    end
  end

  // ---------- bus driver tasks ----------
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_write = 1'b1;
    @(posedge clk); #1;
    bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr_byte(input int idx, input logic [7:0] v);
    bus_wr(8'(128 + idx - idx % 4), 32'(v) << (8 * (idx % 4)), 4'b0001 << (idx % 4));
    mdl[idx] = v;
  endtask

  task automatic rd_byte(input int idx, output logic [7:0] v);
    logic [31:0] w;
    bus_rd(8'(128 + idx - idx % 4), w);
    v = w[8 * (idx % 4) +: 8];
  endtask

  task automatic run_cmd(input int cs, input logic [7:0] op, input int tx, input int rx,
                         input bit clr, input bit meddle);
    logic [31:0] r;
    logic [7:0]  v;
    int guard, start_ptr, rises_done;
    seed = seed + 17;
    if (clr) mptr = 0;
    start_ptr = mptr;
    exp_q.delete();
    exp_q.push_back(op);
    for (int i = 0; i < tx; i++) exp_q.push_back(mdl[mptr + i]);
    cur_tx = tx;
    sclk_rises = 0;
    bus_wr(8'h00, 32'(op), 4'b0001);
    bus_wr(8'h1C, 32'(cs) << 8, 4'b0010);
    bus_wr(8'h48, {8'(rx), 16'h0, 8'(tx)}, 4'b1001);
    if (clr) bus_wr(8'h00, 32'h0010_0000, 4'b0100);
    bus_wr(8'h00, 32'h0001_0000, 4'b0100);
    bus_rd(8'h00, r);
    check(r[31] == 1'b1 && r[16] == 1'b0, "R2 busy set, execute bit self-cleared", r, 32'h8000_0000 | 32'(op));
    repeat (HALF) @(negedge clk);
    check(cs_n == ~(4'b0001 << cs), "R4 selected chip select low", 32'(cs_n), 32'(~(4'b0001 << cs) & 4'hF));
    if (meddle) begin
      bus_wr(8'h00, 32'h0000_00EE, 4'b0001);
      bus_wr(8'h48, 32'h0500_0005, 4'b1001);
      bus_wr(8'h1C, 32'h0000_0300, 4'b0010);
      bus_wr(8'h80, 32'hFFFF_FFFF, 4'b1111);
      bus_wr(8'h00, 32'h0001_0000, 4'b0100);
    end
    guard = 0;
    do begin
      bus_rd(8'h00, r);
      guard++;
    end while (r[31] && guard < 20000);
    check(r[31] == 1'b0, "R2 busy returns to 0", r, 0);
    check(sclk_rises == 8 * (1 + tx + rx), "R6 rising edge count", 32'(sclk_rises), 32'(8 * (1 + tx + rx)));
    check(exp_q.size() == 0, "R3 all transmit bytes seen", 32'(exp_q.size()), 0);
    check(cs_n == 4'hF && sclk == 1'b0, "R10 link idle after command", {27'h0, sclk, cs_n}, 32'hF);
    for (int j = 0; j < rx; j++) begin
      rd_byte(mptr + tx + j, v);
      mdl[mptr + tx + j] = reply_f(1 + tx + j, seed);
      check(v == mdl[mptr + tx + j], "R5 received byte at tx offset", 32'(v), 32'(mdl[mptr + tx + j]));
    end
    mptr = mptr + tx + rx;
    if (meddle) begin
      rises_done = sclk_rises;
      bus_rd(8'h00, r);
      check(r[7:0] == op, "R8 opcode kept while busy", 32'(r[7:0]), 32'(op));
      bus_rd(8'h48, r);
      check(r == {8'(rx), 16'h0, 8'(tx)}, "R8 counts kept while busy", r, {8'(rx), 16'h0, 8'(tx)});
      bus_rd(8'h1C, r);
      check(r[9:8] == 2'(cs), "R8 select kept while busy", 32'(r[9:8]), 32'(cs));
      rd_byte(start_ptr, v);
      check(v == mdl[start_ptr], "R8 FIFO kept while busy", 32'(v), 32'(mdl[start_ptr]));
      repeat (20) @(negedge clk);
      bus_rd(8'h00, r);
      check(r[31] == 1'b0 && sclk_rises == rises_done, "R8 second execute ignored", 32'(sclk_rises), 32'(rises_done));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(8'h00, r); check(r == 0, "R1 control word after reset", r, 0);
    bus_rd(8'h48, r); check(r == 0, "R1 counts after reset", r, 0);
    bus_rd(8'h1C, r); check(r == 0, "R1 select after reset", r, 0);
    check(cs_n == 4'hF && sclk == 1'b0, "R1 link idle after reset", {27'h0, sclk, cs_n}, 32'hF);

    // R7 byte-lane mapping of the FIFO window
    for (int i = 0; i < 8; i++) wr_byte(i, 8'(8'h10 + 8'(i * 7)));
    bus_rd(8'h80, r); check(r == {mdl[3], mdl[2], mdl[1], mdl[0]}, "R7 FIFO word 0", r, {mdl[3], mdl[2], mdl[1], mdl[0]});
    bus_rd(8'h84, r); check(r == {mdl[7], mdl[6], mdl[5], mdl[4]}, "R7 FIFO word 1", r, {mdl[7], mdl[6], mdl[5], mdl[4]});

    run_cmd(2, 8'h9F, 0, 3, 1, 0);   // receive only (R5)
    for (int i = 0; i < 4; i++) wr_byte(i, 8'(8'hC0 + 8'(i)));
    run_cmd(0, 8'h02, 4, 0, 1, 0);   // transmit only (R3)
    run_cmd(3, 8'h0B, 3, 2, 1, 0);   // both phases
    run_cmd(1, 8'h06, 0, 0, 1, 0);   // opcode only (R6)
    run_cmd(0, 8'h5A, 2, 1, 1, 0);   // pointer ends at 3
    run_cmd(2, 8'h77, 1, 0, 0, 0);   // R9: no clear, continues at offset 3
    wr_byte(0, 8'hC4);
    run_cmd(1, 8'h33, 1, 1, 1, 1);   // R8 writes during busy

    // R9 clear bit reads back 0
    bus_wr(8'h00, 32'h0010_0000, 4'b0100);
    bus_rd(8'h00, r);
    check(r[20] == 1'b0 && r[31] == 1'b0, "R9 clear bit self-clears", r, 32'h33);

    // full FIFO: 70 transmit bytes, 2 received into the last entries
    for (int i = 0; i < 70; i++) wr_byte(i, 8'(8'hA1 + 8'(i * 3)));
    run_cmd(3, 8'hC3, 70, 2, 1, 0);

    finish_run();
  end
endmodule